// File: doc/BRIEF.md
# Processing-Element Activity Mask Stack

Each processing element of an associative array owns one copy of this unit. It holds a small stack of one-bit activity flags and a one-bit responder register. The stack entry on top tells whether the element is currently active. A masked instruction may execute in this element only while that entry is 1. An unmasked instruction executes whatever the stack holds.

The array controller broadcasts a three-bit operation code every cycle. The operations set the top entry, load the responder from the AND of two logical-register results, and copy the top entry into the responder. A push nests one more level of association: it stores the AND of the responder and the current top as a new top entry, and writes the same value back into the responder. A pop returns to the enclosing level. A push on a full stack and a pop that would empty the stack are both refused, and a one-cycle flag reports each refusal.

Top module: `msk_ctrl`

## Requirements
- R1: Once reset has been applied (synchronous, active low), the stack holds one entry of value 1, `level` reads 1, `top_bit` reads 1, `resp_bit` reads 0, and both flags read 0.
- R2: `exec_ok` equals `top_bit` while `is_masked` is 1, and it is 1 while `is_masked` is 0.
- R3: Op code 1 (set) writes 1 into the top entry. The level and the responder do not change.
- R4: Op code 5 (load responder) stores `lr_a AND lr_b` into the responder. The stack does not change.
- R5: Op code 2 (push), with fewer than DEPTH entries held, pushes `resp AND top` as the new top, writes the same value into the responder, and adds one to the level.
- R6: Op code 3 (pop), with more than one entry held, takes one from the level and exposes the entry beneath, so that values come back in last-in-first-out order.
- R7: A pop with one entry held changes nothing, and `unf_pulse` is 1 for exactly the following cycle.
- R8: A push with DEPTH (16) entries held changes neither the stack nor the responder, and `ovf_pulse` is 1 for exactly the following cycle.
- R9: Op code 4 (copy) loads the responder from the top entry. The stack does not change.
- R10: Op codes 0, 6 and 7 change neither the stack nor the responder.
- R11: Every operation takes effect at the rising clock edge on which it is presented. `level`, `top_bit`, `resp_bit` and the flags show the result in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 3 | Operation: 0 none, 1 set, 2 push, 3 pop, 4 copy, 5 load responder, 6-7 none |
| lr_a | input | 1 | First logical-register result for the load-responder operation |
| lr_b | input | 1 | Second logical-register result for the load-responder operation |
| is_masked | input | 1 | The instruction being issued is a masked one |
| exec_ok | output | 1 | This element may execute the instruction being issued |
| top_bit | output | 1 | Current top entry of the stack |
| resp_bit | output | 1 | Responder register |
| level | output | 5 | Number of entries held, 1 to 16 |
| ovf_pulse | output | 1 | Push on a full stack was refused in the previous cycle |
| unf_pulse | output | 1 | Pop on a single-entry stack was refused in the previous cycle |

## Verification
A wrong stack pointer shows on `level` in the cycle right after the offending operation. A corrupted entry stays hidden until pops bring it to the top, and it then appears on `top_bit` and `exec_ok`. For that reason the bench fills the stack to the limit with varied values and empties it again. It compares every exposed entry against a model that computes the stack contents independently. A responder that takes the wrong value shows on `resp_bit` one cycle after the operation, and it also shows later in the value that the next push stores.

// File: rtl/msk_pkg.sv
// Package: operation codes shared by the mask stack controller and its parts.
// Assumes a 3-bit operation field broadcast by the array controller.
package msk_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SET   = 3'd1,
        OP_PUSH  = 3'd2,
        OP_POP   = 3'd3,
        OP_COPY  = 3'd4,
        OP_LDRSP = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } msk_op_e;
endpackage

// File: rtl/msk_store.sv
// Module: one-bit-wide activity stack with an occupancy counter.
// Holds between 1 and DEPTH entries. The caller must not request push and
// pop in the same cycle. Refused requests (push when full, pop at one entry)
// leave the state untouched.
module msk_store #(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_top,
    input  logic          push_req,
    input  logic          push_val,
    input  logic          pop_req,
    output logic          top_o,
    output logic [CW-1:0] lvl_o,
    output logic          full_o,
    output logic          single_o
);
    logic [CW-1:0]    cnt;
    logic [DEPTH-1:0] stk;
    logic [IW-1:0]    top_ix;
    logic [IW-1:0]    nxt_ix;
    logic             push_ok;
    logic             pop_ok;

    // Pointer arithmetic and the acceptance of each request.
    always_comb begin
        top_ix  = IW'(cnt - CW'(1));
        nxt_ix  = IW'(cnt);
        push_ok = push_req && (cnt != CW'(DEPTH));
        pop_ok  = pop_req && (cnt != CW'(1));
    end

    // One flop per entry. An entry is written by a push aimed at it or by a set of the top.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        localparam logic RST_V = (gi == 0);
        always_ff @(posedge clk) begin
            if (!rst_n)
                stk[gi] <= RST_V;
            else if (push_ok && nxt_ix == IW'(gi))
                stk[gi] <= push_val;
            else if (set_top && top_ix == IW'(gi))
                stk[gi] <= 1'b1;
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CW'(1);
        else if (push_ok)
            cnt <= cnt + CW'(1);
        else if (pop_ok)
            cnt <= cnt - CW'(1);
    end

    assign top_o    = stk[top_ix];
    assign lvl_o    = cnt;
    assign full_o   = (cnt == CW'(DEPTH));
    assign single_o = (cnt == CW'(1));

    // R1
    depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= CW'(1)) && (cnt <= CW'(DEPTH)));
    // R5
    push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !full_o) |=> (cnt == $past(cnt) + CW'(1)) && (top_o == $past(push_val)));
    // R6
    pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !single_o) |=> (cnt == $past(cnt) - CW'(1)));
    // R3
    set_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_top && !push_req && !pop_req) |=> (top_o == 1'b1) && $stable(cnt));
endmodule

// File: rtl/msk_resp.sv
// Module: responder register of one processing element.
// Loads ld_val when ld_en is high and holds otherwise. It clears on reset.
module msk_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_en,
    input  logic ld_val,
    output logic resp_o
);
    // Responder storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            resp_o <= 1'b0;
        else if (ld_en)
            resp_o <= ld_val;
    end

    // R10
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && $past(rst_n)) |=> $stable(resp_o));
endmodule

// File: rtl/msk_ctrl.sv
// Module: activity mask stack controller for one processing element.
// Decodes the broadcast operation code, drives the stack and the responder,
// gates masked instructions, and reports refused push or pop operations
// through one-cycle flags. Assumes one operation per cycle.
module msk_ctrl #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_code,
    input  logic          lr_a,
    input  logic          lr_b,
    input  logic          is_masked,
    output logic          exec_ok,
    output logic          top_bit,
    output logic          resp_bit,
    output logic [CW-1:0] level,
    output logic          ovf_pulse,
    output logic          unf_pulse
);
    import msk_pkg::*;

    msk_op_e op;
    logic    do_set, do_push, do_pop;
    logic    full, single;
    logic    push_val;
    logic    rsp_ld;
    logic    rsp_val;

    // Operation decode and the responder load source.
    always_comb begin
        op       = msk_op_e'(op_code);
        do_set   = (op == OP_SET);
        do_push  = (op == OP_PUSH);
        do_pop   = (op == OP_POP);
        push_val = resp_bit & top_bit;
        rsp_ld   = 1'b0;
        rsp_val  = 1'b0;
        unique case (op)
            OP_PUSH:  begin rsp_ld = !full; rsp_val = push_val; end
            OP_COPY:  begin rsp_ld = 1'b1;  rsp_val = top_bit;  end
            OP_LDRSP: begin rsp_ld = 1'b1;  rsp_val = lr_a & lr_b; end
            default:  begin rsp_ld = 1'b0;  rsp_val = 1'b0;     end
        endcase
    end

    msk_store #(.DEPTH(DEPTH)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_top  (do_set),
        .push_req (do_push),
        .push_val (push_val),
        .pop_req  (do_pop),
        .top_o    (top_bit),
        .lvl_o    (level),
        .full_o   (full),
        .single_o (single)
    );

    msk_resp i_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (rsp_ld),
        .ld_val (rsp_val),
        .resp_o (resp_bit)
    );

    // Refusal flags, each high for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_pulse <= 1'b0;
            unf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= do_push && full;
            unf_pulse <= do_pop && single;
        end
    end

    // Execution gate for the instruction being issued.
    assign exec_ok = !is_masked || top_bit;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $stable(level) && $stable(resp_bit) && (level == CW'(DEPTH)));
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_pulse |-> $stable(level) && (level == CW'(1)));
    // R9
    copy_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && op_code == 3'd4) |=> (resp_bit == $past(top_bit)) && $stable(level));
    // R5
    push_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && op_code == 3'd2 && level != CW'(DEPTH))
        |=> (resp_bit == top_bit) && (resp_bit == $past(resp_bit & top_bit)));
    // R2
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_masked && !top_bit) |-> !exec_ok);
endmodule

// File: tb/test_msk_ctrl.sv
// Bench: runs directed and pseudo-random operations against an arithmetic model of the stack.
module test_msk_ctrl;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic       lr_a = 1'b0, lr_b = 1'b0, is_masked = 1'b0;
    logic       exec_ok, top_bit, resp_bit, ovf_pulse, unf_pulse;
    logic [4:0] level;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit mstk [DEPTH];
    int mcnt;
    bit mresp;
    bit eovf, eunf;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    msk_ctrl #(.DEPTH(DEPTH)) i_msk_ctrl (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .lr_a(lr_a), .lr_b(lr_b),
        .is_masked(is_masked), .exec_ok(exec_ok), .top_bit(top_bit),
        .resp_bit(resp_bit), .level(level), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compares every output with the model. Called at a falling edge.
    task automatic compare(input string req);
        chk({req, " level"}, int'(level), mcnt);
        chk({req, " top"}, int'(top_bit), int'(mstk[mcnt-1]));
        chk({req, " resp"}, int'(resp_bit), int'(mresp));
        chk({req, " R8 ovf"}, int'(ovf_pulse), int'(eovf));
        chk({req, " R7 unf"}, int'(unf_pulse), int'(eunf));
        chk({req, " R2 exec"}, int'(exec_ok), is_masked ? int'(mstk[mcnt-1]) : 1);
    endtask

    // Drives one operation at a falling edge, updates the model at the rising edge,
    // then checks at the next falling edge (R11).
    task automatic step(input int op, input bit a, input bit b, input bit m);
        string req;
        op_code = 3'(op); lr_a = a; lr_b = b; is_masked = m;
        @(posedge clk);
        eovf = 0; eunf = 0;
        case (op)
            1: begin req = "R3 set"; mstk[mcnt-1] = 1; end
            2: if (mcnt == DEPTH) begin req = "R8 push-full"; eovf = 1; end
               else begin
                   req = "R5 push";
                   mstk[mcnt] = mresp & mstk[mcnt-1];
                   mresp = mstk[mcnt];
                   mcnt++;
               end
            3: if (mcnt == 1) begin req = "R7 pop-last"; eunf = 1; end
               else begin req = "R6 pop"; mcnt--; end
            4: begin req = "R9 copy"; mresp = mstk[mcnt-1]; end
            5: begin req = "R4 load"; mresp = a & b; end
            default: req = "R10 none";
        endcase
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        op_code = 3'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) mstk[i] = 0;
        mstk[0] = 1; mcnt = 1; mresp = 0; eovf = 0; eunf = 0;
        op_code = 3'd0;
        // R1: state immediately after reset
        compare("R1 reset");
        is_masked = 1'b1; #1; chk("R2 masked exec", int'(exec_ok), 1);
        // R7: pop at a single entry
        step(3, 0, 0, 1);
        step(0, 0, 0, 0);
        // R4: all input pairs
        for (int k = 0; k < 4; k++) step(5, k[0], k[1], k[0]);
        // R5/R8: fill to the limit with varied values, then overrun
        for (int i = 0; i < DEPTH + 2; i++) begin
            if (i % 3 == 0) step(1, 0, 0, 0);
            step(5, i[0] | i[2], 1'b1, i[1]);
            step(2, 0, 0, 1);
        end
        // R10: reserved codes on a full stack
        step(6, 1, 1, 1); step(7, 1, 1, 0); step(0, 1, 1, 1);
        // R6/R7: empty in LIFO order, then underflow
        for (int i = 0; i < DEPTH + 1; i++) begin
            step(4, 0, 0, 1);
            step(3, 0, 0, i[0]);
        end
        // Pseudo-random walk with pushes weighted to reach both limits
        for (int n = 0; n < 6000; n++) begin
            int op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = int'(lfsr[2:0]);
            if (n % 1500 < 700 && lfsr[5:4] == 2'b11) op = 2;
            if (n % 1500 >= 700 && lfsr[5:4] == 2'b11) op = 3;
            step(op, lfsr[7], lfsr[9], lfsr[11]);
        end
        // R1: reset from a deep stack
        rst_n = 1'b0; op_code = 3'd2;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1; op_code = 3'd0;
        for (int i = 0; i < DEPTH; i++) mstk[i] = 0;
        mstk[0] = 1; mcnt = 1; mresp = 0; eovf = 0; eunf = 0;
        compare("R1 re-reset");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule